// File: doc/BRIEF.md
# Parallel port host handshake controller

This block is the host end of a byte-wide, half-duplex parallel link. In the outbound direction it takes bytes from an internal valid/ready interface and presents each one on an 8-bit bus. Each byte carries a tag that says whether it is a command or a data byte. The block then runs a strobe/acknowledge exchange with the peripheral. In the inbound direction it asks the peripheral to turn the bus around and releases its bus drivers. It then accepts bytes that the peripheral clocks in, acknowledging each one and reporting the byte together with its command/data tag.

One host output line has two jobs. While sending, it marks the byte type. While receiving, it is the host's acknowledge. Every peripheral input passes through a two-flop synchronizer before the state machine sees it. A programmable cycle limit guards every wait on the peripheral. When the limit is hit, the block pulses a timeout flag and falls back to its idle state; a timed-out inbound session is torn down.

Top module: `pp_host_link`

## Requirements
- R1: After reset, `host_stb` is 1, `host_tag` is 0, `dir_req_n` is 1, `bus_oe` is 1, `rx_valid` and `tmo_flag` are 0, and `tx_ready` is 1 while `pr_tag_i` is low.
- R2: When a byte is accepted (`tx_valid` and `tx_ready` high at a rising edge), `bus_out` takes the byte and `host_tag` takes 1 for data or 0 for a command (`tx_is_cmd`=1) at that edge. `host_stb` falls one edge later, and both `bus_out` and `host_tag` stay stable while `host_stb` is low.
- R3: Once `host_stb` is low, it stays low until `pr_tag_i` is seen high. It then rises three edges after `pr_tag_i` rises.
- R4: While `pr_tag_i` stays high after a byte, `tx_ready` is 0 and `tx_valid` has no effect on `bus_out`. `tx_ready` returns three edges after `pr_tag_i` falls.
- R5: While idle, a high `rev_req` drives `dir_req_n` low at the next edge. `bus_oe` drops three edges after `dir_ack_n_i` falls.
- R6: In inbound mode, `host_tag` rises three edges after `pr_stb_i` falls. Three edges after `pr_stb_i` rises, the block pulses `rx_valid` for one cycle with `rx_byte` equal to `bus_in` and `rx_is_data` equal to the `pr_tag_i` level seen while `pr_stb_i` was low; `host_tag` returns to 0 at that same edge.
- R7: When `rev_req` goes low in inbound mode, `dir_req_n` returns high at the next edge. `bus_oe` stays 0 until `dir_ack_n_i` is high again, and returns three edges after that.
- R8: A wait on the peripheral that lasts `tmo_limit`+1 edges ends with a one-cycle `tmo_flag` pulse. An outbound timeout returns `host_stb` high; an inbound-entry timeout returns `dir_req_n` high.
- R9: While `dir_req_n` is low, `tx_ready` is 0, `host_stb` stays high and `tx_valid` leaves `bus_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmo_limit | input | TMO_W | Handshake wait limit in cycles |
| tx_valid | input | 1 | Outbound byte offered |
| tx_is_cmd | input | 1 | Outbound byte is a command |
| tx_byte | input | DATA_W | Outbound byte |
| tx_ready | output | 1 | Outbound byte can be taken this cycle |
| rev_req | input | 1 | Request inbound mode (level) |
| rx_valid | output | 1 | One-cycle pulse: inbound byte ready |
| rx_byte | output | DATA_W | Inbound byte |
| rx_is_data | output | 1 | Inbound byte was tagged as data |
| tmo_flag | output | 1 | One-cycle pulse on a handshake timeout |
| bus_out | output | DATA_W | Bus value driven by the host |
| bus_oe | output | 1 | Host bus driver enable (tristate control) |
| bus_in | input | DATA_W | Bus value seen at the pins |
| host_stb | output | 1 | Host strobe, low while outbound data is valid |
| host_tag | output | 1 | Outbound type mark / inbound acknowledge |
| dir_req_n | output | 1 | Active-low inbound direction request |
| pr_tag_i | input | 1 | Peripheral acknowledge / inbound type mark |
| pr_stb_i | input | 1 | Peripheral strobe, low while inbound data is valid |
| dir_ack_n_i | input | 1 | Active-low peripheral grant of inbound mode |

## Verification
Each response to a peripheral line is due exactly three rising edges after that line changes: two synchronizer flops, then the registered output. The strobe falls one edge after acceptance, and a timeout pulse arrives `tmo_limit`+1 edges after the wait opens. The bench changes every input on a falling edge and then steps one edge at a time, sampling at the next falling edge. It compares the number of edges until the output changes with these exact counts, so a response that comes early or late fails the check just as a wrong value does.

// File: rtl/pp_link_pkg.sv
package pp_link_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_F_SETUP,
    ST_F_STROBE,
    ST_F_RELEASE,
    ST_R_ENTER,
    ST_R_IDLE,
    ST_R_LATCH,
    ST_R_EXIT
  } link_state_e;

  localparam int CTL_LINES = 3;

endpackage

// File: rtl/pp_link_sync.sv
module pp_link_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic sync_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= d_i[i];
        sync_q <= meta_q;
      end
    end
    assign q_o[i] = sync_q;
  end

endmodule

// File: rtl/pp_link_timer.sv
module pp_link_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wait_en,
  input  logic             wait_clr,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !wait_en || wait_clr) begin
      cnt_q <= '0;
    end else if (cnt_q != {CNT_W{1'b1}}) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit = wait_en && (cnt_q >= limit);

  // R8: the wait counter restarts whenever no wait is open
  a_r8_count_restarts: assert property (@(posedge clk) disable iff (rst)
    !wait_en |=> (cnt_q == '0));

endmodule

// File: rtl/pp_link_engine.sv
module pp_link_engine
  import pp_link_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_valid,
  input  logic              tx_is_cmd,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              tx_ready,
  input  logic              rev_req,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_is_data,
  input  logic              tag_s,
  input  logic              stb_s,
  input  logic              dack_n_s,
  input  logic [DATA_W-1:0] data_s,
  input  logic              tmo_hit,
  output logic              wait_en,
  output logic              wait_clr,
  output logic              tmo_flag,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              host_stb,
  output logic              host_tag,
  output logic              dir_req_n
);

  link_state_e state_q, state_d;
  logic        accept;
  logic        tmo_now;
  logic        kind_q;

  assign wait_en = (state_q == ST_F_STROBE) || (state_q == ST_F_RELEASE) ||
                   (state_q == ST_R_ENTER)  || (state_q == ST_R_LATCH);

  assign tx_ready = (state_q == ST_IDLE) && !rev_req && !tag_s;
  assign accept   = tx_ready && tx_valid;

  always_comb begin
    state_d = state_q;
    tmo_now = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (rev_req)     state_d = ST_R_ENTER;
        else if (accept) state_d = ST_F_SETUP;
      end
      ST_F_SETUP: state_d = ST_F_STROBE;
      ST_F_STROBE: begin
        if (tag_s) state_d = ST_F_RELEASE;
        else if (tmo_hit) begin
          state_d = ST_IDLE;
          tmo_now = 1'b1;
        end
      end
      ST_F_RELEASE: begin
        if (!tag_s) state_d = ST_IDLE;
        else if (tmo_hit) begin
          state_d = ST_IDLE;
          tmo_now = 1'b1;
        end
      end
      ST_R_ENTER: begin
        if (!dack_n_s) state_d = ST_R_IDLE;
        else if (tmo_hit) begin
          state_d = ST_R_EXIT;
          tmo_now = 1'b1;
        end
      end
      ST_R_IDLE: begin
        if (!rev_req)     state_d = ST_R_EXIT;
        else if (!stb_s)  state_d = ST_R_LATCH;
      end
      ST_R_LATCH: begin
        if (stb_s) state_d = ST_R_IDLE;
        else if (tmo_hit) begin
          state_d = ST_R_EXIT;
          tmo_now = 1'b1;
        end
      end
      ST_R_EXIT: begin
        if (dack_n_s) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign wait_clr = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      host_stb   <= 1'b1;
      host_tag   <= 1'b0;
      dir_req_n  <= 1'b1;
      bus_oe     <= 1'b1;
      bus_out    <= '0;
      rx_valid   <= 1'b0;
      rx_byte    <= '0;
      rx_is_data <= 1'b0;
      tmo_flag   <= 1'b0;
      kind_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      rx_valid <= 1'b0;
      tmo_flag <= tmo_now;

      if (!dack_n_s)                                 bus_oe <= 1'b0;
      else if (state_q == ST_R_EXIT)                 bus_oe <= 1'b1;

      case (state_q)
        ST_IDLE: begin
          if (rev_req) begin
            dir_req_n <= 1'b0;
            host_tag  <= 1'b0;
          end else if (accept) begin
            bus_out  <= tx_byte;
            host_tag <= !tx_is_cmd;
          end
        end
        ST_F_SETUP: host_stb <= 1'b0;
        ST_F_STROBE: begin
          if (tag_s) host_stb <= 1'b1;
          else if (tmo_hit) begin
            host_stb <= 1'b1;
            host_tag <= 1'b0;
          end
        end
        ST_F_RELEASE: begin
          if (!tag_s || tmo_hit) host_tag <= 1'b0;
        end
        ST_R_ENTER: begin
          if (dack_n_s && tmo_hit) dir_req_n <= 1'b1;
        end
        ST_R_IDLE: begin
          if (!rev_req) dir_req_n <= 1'b1;
          else if (!stb_s) begin
            host_tag <= 1'b1;
            kind_q   <= tag_s;
          end
        end
        ST_R_LATCH: begin
          if (stb_s) begin
            rx_byte    <= data_s;
            rx_is_data <= kind_q;
            rx_valid   <= 1'b1;
            host_tag   <= 1'b0;
          end else if (tmo_hit) begin
            host_tag  <= 1'b0;
            dir_req_n <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R2: bus value and type mark hold while the strobe is low
  a_r2_hold_while_low: assert property (@(posedge clk) disable iff (rst)
    (!host_stb && $past(!host_stb)) |-> ($stable(bus_out) && $stable(host_tag)));

  // R3: the strobe returns high only on a seen acknowledge or a timeout
  a_r3_rise_needs_ack: assert property (@(posedge clk) disable iff (rst)
    $rose(host_stb) |-> ($past(tag_s) || $past(tmo_hit)));

  // R5: a granted turnaround releases the bus drivers
  a_r5_release_bus: assert property (@(posedge clk) disable iff (rst)
    !dack_n_s |=> !bus_oe);

  // R6: inbound byte strobe lasts one cycle
  a_r6_rx_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R8: timeout indication lasts one cycle
  a_r8_tmo_pulse: assert property (@(posedge clk) disable iff (rst)
    tmo_flag |=> !tmo_flag);

  // R9: no outbound strobe while inbound mode is requested
  a_r9_quiet_stb: assert property (@(posedge clk) disable iff (rst)
    !dir_req_n |-> (host_stb && !tx_ready));

endmodule

// File: rtl/pp_host_link.sv
module pp_host_link
  import pp_link_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              tx_valid,
  input  logic              tx_is_cmd,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              tx_ready,
  input  logic              rev_req,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_is_data,
  output logic              tmo_flag,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_in,
  output logic              host_stb,
  output logic              host_tag,
  output logic              dir_req_n,
  input  logic              pr_tag_i,
  input  logic              pr_stb_i,
  input  logic              dir_ack_n_i
);

  localparam logic [CTL_LINES-1:0] CTL_IDLE = 3'b110;

  logic [CTL_LINES-1:0] ctl_s;
  logic [DATA_W-1:0]    data_s;
  logic                 wait_en, wait_clr, tmo_hit;

  pp_link_sync #(.W(CTL_LINES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({dir_ack_n_i, pr_stb_i, pr_tag_i}),
    .q_o (ctl_s)
  );

  pp_link_sync #(.W(DATA_W), .RST_VAL('0)) u_data_sync (
    .clk (clk),
    .rst (rst),
    .d_i (bus_in),
    .q_o (data_s)
  );

  pp_link_timer #(.CNT_W(TMO_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .wait_en  (wait_en),
    .wait_clr (wait_clr),
    .limit    (tmo_limit),
    .hit      (tmo_hit)
  );

  pp_link_engine #(.DATA_W(DATA_W)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .tx_valid   (tx_valid),
    .tx_is_cmd  (tx_is_cmd),
    .tx_byte    (tx_byte),
    .tx_ready   (tx_ready),
    .rev_req    (rev_req),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .rx_is_data (rx_is_data),
    .tag_s      (ctl_s[0]),
    .stb_s      (ctl_s[1]),
    .dack_n_s   (ctl_s[2]),
    .data_s     (data_s),
    .tmo_hit    (tmo_hit),
    .wait_en    (wait_en),
    .wait_clr   (wait_clr),
    .tmo_flag   (tmo_flag),
    .bus_out    (bus_out),
    .bus_oe     (bus_oe),
    .host_stb   (host_stb),
    .host_tag   (host_tag),
    .dir_req_n  (dir_req_n)
  );

endmodule

// File: tb/pp_host_link_tb_top.sv
module pp_host_link_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int TW = 16;
  localparam int LIMIT = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] tmo_limit = TW'(LIMIT);
  logic          tx_valid = 1'b0, tx_is_cmd = 1'b0;
  logic [DW-1:0] tx_byte = '0;
  logic          tx_ready;
  logic          rev_req = 1'b0;
  logic          rx_valid, rx_is_data, tmo_flag, bus_oe;
  logic [DW-1:0] rx_byte, bus_out;
  logic [DW-1:0] bus_in = '0;
  logic          host_stb, host_tag, dir_req_n;
  logic          pr_tag_i = 1'b0, pr_stb_i = 1'b1, dir_ack_n_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_host_link #(.DATA_W(DW), .TMO_W(TW)) dut_i (
    .clk(clk), .rst(rst), .tmo_limit(tmo_limit),
    .tx_valid(tx_valid), .tx_is_cmd(tx_is_cmd), .tx_byte(tx_byte), .tx_ready(tx_ready),
    .rev_req(rev_req), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_is_data(rx_is_data),
    .tmo_flag(tmo_flag), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
    .host_stb(host_stb), .host_tag(host_tag), .dir_req_n(dir_req_n),
    .pr_tag_i(pr_tag_i), .pr_stb_i(pr_stb_i), .dir_ack_n_i(dir_ack_n_i)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic pick(input int sel);
    case (sel)
      0: return host_stb;
      1: return host_tag;
      2: return bus_oe;
      3: return rx_valid;
      4: return tmo_flag;
      5: return tx_ready;
      default: return dir_req_n;
    endcase
  endfunction

  // steps one edge at a time, sampling at falling edges
  task automatic edges_until(input int sel, input logic val, output int n);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (pick(sel) == val) return;
    end
    n = -1;
  endtask

  task automatic step(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "host_stb", host_stb, 1);
    chk("R1", "host_tag", host_tag, 0);
    chk("R1", "dir_req_n", dir_req_n, 1);
    chk("R1", "bus_oe", bus_oe, 1);
    chk("R1", "tx_ready", tx_ready, 1);
    chk("R1", "rx_valid/tmo_flag", {rx_valid, tmo_flag}, 0);
  endtask

  task automatic fwd_byte(input logic [DW-1:0] b, input logic cmd, input bit probe);
    int n;
    tx_valid = 1'b1; tx_byte = b; tx_is_cmd = cmd;
    @(posedge clk); @(negedge clk);
    tx_valid = 1'b0;
    chk("R2", "bus_out at accept", bus_out, b);
    chk("R2", "host_tag type mark", host_tag, cmd ? 0 : 1);
    chk("R2", "strobe still high", host_stb, 1);
    step(1);
    chk("R2", "strobe fell", host_stb, 0);
    step(4);
    chk("R3", "strobe waits for ack", host_stb, 0);
    pr_tag_i = 1'b1;
    edges_until(0, 1'b1, n);
    chk("R3", "edges ack->strobe rise", n, 3);
    if (probe) begin
      tx_valid = 1'b1; tx_byte = ~b; tx_is_cmd = ~cmd;
      step(3);
      chk("R4", "tx_ready while ack high", tx_ready, 0);
      chk("R4", "bus_out unchanged", bus_out, b);
      tx_valid = 1'b0;
    end
    pr_tag_i = 1'b0;
    edges_until(5, 1'b1, n);
    chk("R4", "edges ack low->tx_ready", n, 3);
  endtask

  task automatic t_rev_enter;
    int n;
    rev_req = 1'b1;
    step(1);
    chk("R5", "dir_req_n low", dir_req_n, 0);
    chk("R9", "tx_ready in reverse", tx_ready, 0);
    chk("R5", "bus still driven", bus_oe, 1);
    dir_ack_n_i = 1'b0;
    edges_until(2, 1'b0, n);
    chk("R5", "edges grant->bus release", n, 3);
    tx_valid = 1'b1; tx_byte = 8'hFF; tx_is_cmd = 1'b0;
    step(3);
    chk("R9", "bus_out untouched", bus_out, 8'h81);
    chk("R9", "strobe high in reverse", host_stb, 1);
    tx_valid = 1'b0;
  endtask

  task automatic rev_byte(input logic [DW-1:0] b, input logic is_data);
    int n;
    bus_in = b; pr_tag_i = is_data; pr_stb_i = 1'b0;
    edges_until(1, 1'b1, n);
    chk("R6", "edges stb low->ack high", n, 3);
    pr_stb_i = 1'b1;
    edges_until(3, 1'b1, n);
    chk("R6", "edges stb high->rx_valid", n, 3);
    chk("R6", "rx_byte", rx_byte, b);
    chk("R6", "rx_is_data", rx_is_data, is_data);
    chk("R6", "ack back low", host_tag, 0);
    pr_tag_i = 1'b0; bus_in = 8'h00;
    step(1);
    chk("R6", "rx_valid one cycle", rx_valid, 0);
  endtask

  task automatic t_rev_exit;
    int n;
    rev_req = 1'b0;
    step(1);
    chk("R7", "dir_req_n released", dir_req_n, 1);
    step(5);
    chk("R7", "bus held off until grant drops", bus_oe, 0);
    dir_ack_n_i = 1'b1;
    edges_until(2, 1'b1, n);
    chk("R7", "edges grant high->bus driven", n, 3);
    chk("R7", "tx_ready back", tx_ready, 1);
  endtask

  task automatic t_fwd_timeout;
    int n;
    tx_valid = 1'b1; tx_byte = 8'h42; tx_is_cmd = 1'b0;
    @(posedge clk); @(negedge clk);
    tx_valid = 1'b0;
    step(1);
    chk("R8", "strobe low before timeout", host_stb, 0);
    edges_until(4, 1'b1, n);
    chk("R8", "edges to forward timeout", n, LIMIT + 1);
    chk("R8", "strobe restored", host_stb, 1);
    step(1);
    chk("R8", "timeout pulse ends", tmo_flag, 0);
    chk("R8", "idle after timeout", tx_ready, 1);
  endtask

  task automatic t_rev_timeout;
    int n;
    rev_req = 1'b1;
    step(1);
    chk("R8", "dir_req_n low", dir_req_n, 0);
    edges_until(4, 1'b1, n);
    rev_req = 1'b0;
    chk("R8", "edges to entry timeout", n, LIMIT + 1);
    chk("R8", "dir_req_n restored", dir_req_n, 1);
    chk("R8", "bus never released", bus_oe, 1);
    step(2);
    chk("R8", "idle after entry timeout", tx_ready, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step(1);
    t_reset();
    fwd_byte(8'hA5, 1'b0, 1'b1);
    fwd_byte(8'h3C, 1'b1, 1'b0);
    fwd_byte(8'h81, 1'b0, 1'b0);
    t_rev_enter();
    rev_byte(8'h5A, 1'b1);
    rev_byte(8'hC3, 1'b0);
    t_rev_exit();
    t_fwd_timeout();
    t_rev_timeout();
    fwd_byte(8'h17, 1'b1, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements actual=expired expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule